// File: doc/BRIEF.md
# Microcoded Stack-Machine Datapath

This block is the execution datapath of a small 16-bit stack-oriented processor. It carries out one horizontal micro-instruction per clock. The micro-instruction comes in as a packed bus. Its fields steer an ALU, three 16-bit registers (A, B, C), a program counter, a byte-wide memory port and the data ports to an external stack unit. Every field takes effect in the same cycle. Register and PC updates land on the next rising clock edge.

A write to a register picks its source from stack pop data, the memory read byte or the ALU result. The high byte is then formed in one of five ways: copy of the low byte, zero, sign extension, ALU high byte, or the source's own high byte. Each register has separate write enables for its low and high bytes. The PC can hold, step, jump to the ALU result, jump to the ALU result only when BL is nonzero, or load an external micro-vector. A terminal bit in the micro-instruction raises an end-of-instruction pulse in the cycle that micro-instruction runs.

The block holds no sequencing state of its own. The architectural registers are its only storage, and an external sequencer supplies the micro-instructions.

Top module: `ucdp_top`

## Requirements
- R1: An active-low reset clears A, B, C and the PC to zero.
- R2: The ALU function field gives PASS=0 (operand 0), ADD=1, SUB=2 (op0 minus op1) and MUL=3 (low 16 bits of the product).
- R3: The ALU function field gives EOR=4, AND=11 and ORA=12 as bitwise operations. Unused codes yield zero.
- R4: EQU=6, NEQ=7, GTH=8 (op0 > op1) and LTH=9 (op0 < op1) compare unsigned. They return 1 or 0 in bit 0, with every other bit zero.
- R5: SFT=5 shifts operand 0 right by operand 1 bits [3:0], then shifts the result left by operand 1 bits [7:4].
- R6: The operand 0 field selects A (0) or zero (1). The operand 1 field selects constant one (0), B (1) or the PC (2).
- R7: The write-source field selects pop data (0), memory byte zero-extended to 16 bits (1) or ALU result (2). The low byte written is the source's low byte.
- R8: The high-byte mode sets the written high byte to one of: a copy of the low byte (0), zero (1), the sign of the low byte (2), the ALU result high byte (3), or the source high byte (4).
- R9: The write-enable vectors hold one bit per register (bit 0 A, bit 1 B, bit 2 C), one vector for low bytes and one for high bytes. A byte whose enable is clear keeps its value.
- R10: The PC function field selects hold (0), increment (1), load ALU result (2) or load the micro-vector input (4). The new value shows on the next cycle.
- R11: PC function 3 loads the ALU result when BL (B bits [7:0]) is nonzero, and holds the PC otherwise.
- R12: The memory function field gives:
  - idle (0): no strobe;
  - read at A (1) and read at PC (2): read strobe;
  - store BL at A (3) and store BH at A (4): write strobe.

  The address is the PC for code 2 and A for all other codes. The device bit is passed to the memory port unchanged.
- R13: The stack function field gives idle (0), push (1) or pop (2). The return-stack bit and the 2-bit size field pass through unchanged. The push-data source field selects ALU result (0), A (1), B (2), C (3) or PC (4).
- R14: The end-of-instruction output is high exactly in the cycles whose micro-instruction has its terminal bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| uinst_i | input | 34 | Packed micro-instruction (`uinst_t`) |
| uvec_i | input | 16 | Micro-vector target for PC function 4 |
| pop_data_i | input | 16 | Data popped from the stack unit |
| push_data_o | output | 16 | Data offered to the stack unit |
| stk_push_o | output | 1 | Push strobe |
| stk_pop_o | output | 1 | Pop strobe |
| stk_ret_o | output | 1 | Selects the return stack instead of the working stack |
| stk_size_o | output | 2 | Stack transfer size, passed through |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 8 | Memory read byte, valid in the request cycle |
| mem_wdata_o | output | 8 | Memory store byte |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_dev_o | output | 1 | Device space (1) or RAM (0) |
| pc_o | output | 16 | Program counter |
| eoi_o | output | 1 | End-of-instruction pulse |

## Verification
Memory strobes, address, store data, stack strobes, push data and the end pulse are combinational in the current micro-instruction. The bench compares them in the same cycle the micro-instruction is applied, 2 ns after the falling edge and before the next rising edge. A register or PC update appears one cycle later. The bench therefore issues a following micro-instruction that routes that register, or the PC, to the push-data port, and checks it there. The driver queues each expectation with the micro-instruction that makes it due, and the monitor empties the queue at that sampling point.

// File: rtl/ucdp_pkg.sv
`timescale 1ns/1ps
package ucdp_pkg;

    localparam int XLEN   = 16;
    localparam int BYTE_W = XLEN / 2;
    localparam int NREG   = 3;
    localparam int SH_W   = $clog2(XLEN);

    localparam int REG_A = 0;
    localparam int REG_B = 1;
    localparam int REG_C = 2;

    typedef enum logic [3:0] {
        ALU_PASS = 4'd0,
        ALU_ADD  = 4'd1,
        ALU_SUB  = 4'd2,
        ALU_MUL  = 4'd3,
        ALU_EOR  = 4'd4,
        ALU_SFT  = 4'd5,
        ALU_EQU  = 4'd6,
        ALU_NEQ  = 4'd7,
        ALU_GTH  = 4'd8,
        ALU_LTH  = 4'd9,
        ALU_AND  = 4'd11,
        ALU_ORA  = 4'd12
    } alu_fn_e;

    typedef enum logic {
        OPA_REG  = 1'b0,
        OPA_ZERO = 1'b1
    } opa_e;

    typedef enum logic [1:0] {
        OPB_ONE = 2'd0,
        OPB_REG = 2'd1,
        OPB_PC  = 2'd2
    } opb_e;

    typedef enum logic [2:0] {
        PC_HOLD    = 3'd0,
        PC_STEP    = 3'd1,
        PC_JUMP    = 3'd2,
        PC_JUMP_NZ = 3'd3,
        PC_VECTOR  = 3'd4
    } pc_fn_e;

    typedef enum logic [1:0] {
        WSRC_POP = 2'd0,
        WSRC_MEM = 2'd1,
        WSRC_ALU = 2'd2
    } wsrc_e;

    typedef enum logic [2:0] {
        HI_COPY_LO = 3'd0,
        HI_ZERO    = 3'd1,
        HI_SIGN    = 3'd2,
        HI_ALU     = 3'd3,
        HI_SRC     = 3'd4
    } hmode_e;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_fn_e;

    typedef enum logic [2:0] {
        PSRC_ALU = 3'd0,
        PSRC_A   = 3'd1,
        PSRC_B   = 3'd2,
        PSRC_C   = 3'd3,
        PSRC_PC  = 3'd4
    } psrc_e;

    typedef enum logic [2:0] {
        MEM_IDLE  = 3'd0,
        MEM_RD_A  = 3'd1,
        MEM_RD_PC = 3'd2,
        MEM_ST_LO = 3'd3,
        MEM_ST_HI = 3'd4
    } mem_fn_e;

    typedef struct packed {
        logic            last;
        alu_fn_e         alu_fn;
        opa_e            opa;
        opb_e            opb;
        pc_fn_e          pc_fn;
        logic [NREG-1:0] we_lo;
        logic [NREG-1:0] we_hi;
        wsrc_e           wsrc;
        hmode_e          hmode;
        logic            stk_ret;
        stk_fn_e         stk_fn;
        psrc_e           psrc;
        logic [1:0]      stk_size;
        mem_fn_e         mem_fn;
        logic            mem_dev;
    } uinst_t;

    localparam int UI_W = $bits(uinst_t);

endpackage

// File: rtl/ucdp_alu.sv
`timescale 1ns/1ps
module ucdp_alu
    import ucdp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] op0,
    input  logic [XLEN-1:0] op1,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] shr;
    logic [SH_W-1:0] rsh;
    logic [SH_W-1:0] lsh;

    assign rsh = op1[SH_W-1:0];
    assign lsh = op1[2*SH_W-1:SH_W];
    assign shr = op0 >> rsh;

    always_comb begin
        case (fn)
            ALU_PASS: res = op0;
            ALU_ADD:  res = op0 + op1;
            ALU_SUB:  res = op0 - op1;
            ALU_MUL:  res = op0 * op1;
            ALU_EOR:  res = op0 ^ op1;
            ALU_SFT:  res = shr << lsh;
            ALU_EQU:  res = {{(XLEN-1){1'b0}}, op0 == op1};
            ALU_NEQ:  res = {{(XLEN-1){1'b0}}, op0 != op1};
            ALU_GTH:  res = {{(XLEN-1){1'b0}}, op0 > op1};
            ALU_LTH:  res = {{(XLEN-1){1'b0}}, op0 < op1};
            ALU_AND:  res = op0 & op1;
            ALU_ORA:  res = op0 | op1;
            default:  res = '0;
        endcase
    end

    AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fn inside {ALU_EQU, ALU_NEQ, ALU_GTH, ALU_LTH}) |-> (res[XLEN-1:1] == '0)); // R4

endmodule

// File: rtl/ucdp_regs.sv
`timescale 1ns/1ps
module ucdp_regs
    import ucdp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0]           we_lo,
    input  logic [NREG-1:0]           we_hi,
    input  wsrc_e                     wsrc,
    input  hmode_e                    hmode,
    input  logic [XLEN-1:0]           pop_data,
    input  logic [BYTE_W-1:0]         mem_byte,
    input  logic [XLEN-1:0]           alu_res,
    output logic [NREG-1:0][XLEN-1:0] q
);

    logic [XLEN-1:0]   src;
    logic [BYTE_W-1:0] wr_lo;
    logic [BYTE_W-1:0] wr_hi;

    always_comb begin
        case (wsrc)
            WSRC_POP: src = pop_data;
            WSRC_MEM: src = {{(XLEN-BYTE_W){1'b0}}, mem_byte};
            WSRC_ALU: src = alu_res;
            default:  src = '0;
        endcase
    end

    assign wr_lo = src[BYTE_W-1:0];

    always_comb begin
        case (hmode)
            HI_COPY_LO: wr_hi = src[BYTE_W-1:0];
            HI_ZERO:    wr_hi = '0;
            HI_SIGN:    wr_hi = {BYTE_W{src[BYTE_W-1]}};
            HI_ALU:     wr_hi = alu_res[XLEN-1:BYTE_W];
            HI_SRC:     wr_hi = src[XLEN-1:BYTE_W];
            default:    wr_hi = '0;
        endcase
    end

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[gi] <= '0;
            end else begin
                if (we_lo[gi]) q[gi][BYTE_W-1:0]    <= wr_lo;
                if (we_hi[gi]) q[gi][XLEN-1:BYTE_W] <= wr_hi;
            end
        end

        AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (we_lo[gi] && !we_hi[gi]) |=> $stable(q[gi][XLEN-1:BYTE_W])); // R9
        AST_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (we_hi[gi] && !we_lo[gi]) |=> $stable(q[gi][BYTE_W-1:0])); // R9
    end

endmodule

// File: rtl/ucdp_pc.sv
`timescale 1ns/1ps
module ucdp_pc
    import ucdp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pc_fn_e          fn,
    input  logic            bl_nz,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] uvec,
    output logic [XLEN-1:0] pc
);

    logic [XLEN-1:0] pc_nxt;

    always_comb begin
        case (fn)
            PC_HOLD:    pc_nxt = pc;
            PC_STEP:    pc_nxt = pc + 1'b1;
            PC_JUMP:    pc_nxt = alu_res;
            PC_JUMP_NZ: pc_nxt = bl_nz ? alu_res : pc;
            PC_VECTOR:  pc_nxt = uvec;
            default:    pc_nxt = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_nxt;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == PC_STEP) |=> (pc == $past(pc) + 1'b1)); // R10
    AST_PC_NZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == PC_JUMP_NZ && bl_nz) |=> (pc == $past(alu_res))); // R11
    AST_PC_NZ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == PC_JUMP_NZ && !bl_nz) |=> $stable(pc)); // R11

endmodule

// File: rtl/ucdp_top.sv
`timescale 1ns/1ps
module ucdp_top
    import ucdp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [UI_W-1:0]         uinst_i,
    input  logic [XLEN-1:0]         uvec_i,
    input  logic [XLEN-1:0]         pop_data_i,
    output logic [XLEN-1:0]         push_data_o,
    output logic                    stk_push_o,
    output logic                    stk_pop_o,
    output logic                    stk_ret_o,
    output logic [1:0]              stk_size_o,
    output logic [XLEN-1:0]         mem_addr_o,
    input  logic [BYTE_W-1:0]       mem_rdata_i,
    output logic [BYTE_W-1:0]       mem_wdata_o,
    output logic                    mem_rd_o,
    output logic                    mem_wr_o,
    output logic                    mem_dev_o,
    output logic [XLEN-1:0]         pc_o,
    output logic                    eoi_o
);

    uinst_t                    ui;
    logic [NREG-1:0][XLEN-1:0] regs;
    logic [XLEN-1:0]           op0;
    logic [XLEN-1:0]           op1;
    logic [XLEN-1:0]           alu_res;
    logic [XLEN-1:0]           pc;

    assign ui = uinst_t'(uinst_i);

    always_comb begin
        case (ui.opa)
            OPA_ZERO: op0 = '0;
            default:  op0 = regs[REG_A];
        endcase
    end

    always_comb begin
        case (ui.opb)
            OPB_ONE: op1 = {{(XLEN-1){1'b0}}, 1'b1};
            OPB_REG: op1 = regs[REG_B];
            OPB_PC:  op1 = pc;
            default: op1 = '0;
        endcase
    end

    ucdp_alu u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .fn    (ui.alu_fn),
        .op0   (op0),
        .op1   (op1),
        .res   (alu_res)
    );

    ucdp_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_lo    (ui.we_lo),
        .we_hi    (ui.we_hi),
        .wsrc     (ui.wsrc),
        .hmode    (ui.hmode),
        .pop_data (pop_data_i),
        .mem_byte (mem_rdata_i),
        .alu_res  (alu_res),
        .q        (regs)
    );

    ucdp_pc u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fn      (ui.pc_fn),
        .bl_nz   (|regs[REG_B][BYTE_W-1:0]),
        .alu_res (alu_res),
        .uvec    (uvec_i),
        .pc      (pc)
    );

    assign pc_o = pc;

    always_comb begin
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = regs[REG_A];
        mem_wdata_o = regs[REG_B][BYTE_W-1:0];
        case (ui.mem_fn)
            MEM_RD_A:  mem_rd_o = 1'b1;
            MEM_RD_PC: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = pc;
            end
            MEM_ST_LO: mem_wr_o = 1'b1;
            MEM_ST_HI: begin
                mem_wr_o    = 1'b1;
                mem_wdata_o = regs[REG_B][XLEN-1:BYTE_W];
            end
            default: ;
        endcase
    end

    assign mem_dev_o = ui.mem_dev;

    always_comb begin
        case (ui.psrc)
            PSRC_A:  push_data_o = regs[REG_A];
            PSRC_B:  push_data_o = regs[REG_B];
            PSRC_C:  push_data_o = regs[REG_C];
            PSRC_PC: push_data_o = pc;
            default: push_data_o = alu_res;
        endcase
    end

    assign stk_push_o = (ui.stk_fn == STK_PUSH);
    assign stk_pop_o  = (ui.stk_fn == STK_POP);
    assign stk_ret_o  = ui.stk_ret;
    assign stk_size_o = ui.stk_size;
    assign eoi_o      = ui.last;

    AST_ONE_MEM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R12
    AST_ONE_STK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push_o && stk_pop_o)); // R13
    AST_IDLE_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ui.mem_fn == MEM_IDLE) |-> !(mem_rd_o || mem_wr_o)); // R12

endmodule

// File: tb/test_ucdp_top.sv
`timescale 1ns/1ps
module test_ucdp_top;
    import ucdp_pkg::*;

    localparam int S_PUSH = 0, S_PC = 1, S_ADDR = 2, S_WDATA = 3, S_RD = 4,
                   S_WR = 5, S_DEV = 6, S_EOI = 7, S_SPUSH = 8, S_SPOP = 9,
                   S_SRET = 10, S_SSIZE = 11;

    typedef struct {
        string       req;
        int          sig;
        logic [15:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [UI_W-1:0] uinst = '0;
    logic [15:0] uvec = '0;
    logic [15:0] pop_data = '0;
    logic [15:0] push_data;
    logic        stk_push, stk_pop, stk_ret;
    logic [1:0]  stk_size;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, mem_dev;
    logic [15:0] pc;
    logic        eoi;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    ucdp_top i_ucdp_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .uinst_i     (uinst),
        .uvec_i      (uvec),
        .pop_data_i  (pop_data),
        .push_data_o (push_data),
        .stk_push_o  (stk_push),
        .stk_pop_o   (stk_pop),
        .stk_ret_o   (stk_ret),
        .stk_size_o  (stk_size),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .mem_wdata_o (mem_wdata),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_dev_o   (mem_dev),
        .pc_o        (pc),
        .eoi_o       (eoi)
    );

    function automatic logic [15:0] observe(int sig);
        case (sig)
            S_PUSH:  return push_data;
            S_PC:    return pc;
            S_ADDR:  return mem_addr;
            S_WDATA: return {8'h00, mem_wdata};
            S_RD:    return {15'd0, mem_rd};
            S_WR:    return {15'd0, mem_wr};
            S_DEV:   return {15'd0, mem_dev};
            S_EOI:   return {15'd0, eoi};
            S_SPUSH: return {15'd0, stk_push};
            S_SPOP:  return {15'd0, stk_pop};
            S_SRET:  return {15'd0, stk_ret};
            default: return {14'd0, stk_size};
        endcase
    endfunction

    // monitor: compares queued expectations before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = sb.pop_front();
                got = observe(it.sig);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s sig%0d actual %h expected %h", it.req, it.sig, got, it.exp);
                end
            end
        end
    end

    task automatic expect_sig(int sig, logic [15:0] v, string req);
        item_t it;
        it.req = req;
        it.sig = sig;
        it.exp = v;
        sb.push_back(it);
    endtask

    task automatic exec(uinst_t u, logic [15:0] pop, logic [7:0] mrd);
        @(negedge clk);
        uinst     = u;
        pop_data  = pop;
        mem_rdata = mrd;
    endtask

    function automatic uinst_t nop();
        uinst_t u;
        u = '0;
        return u;
    endfunction

    task automatic load(int idx, logic [15:0] v);
        uinst_t u;
        u = nop();
        u.we_lo[idx] = 1'b1;
        u.we_hi[idx] = 1'b1;
        u.wsrc  = WSRC_POP;
        u.hmode = HI_SRC;
        exec(u, v, 8'h00);
    endtask

    task automatic peek(psrc_e src, logic [15:0] v, string req);
        uinst_t u;
        u = nop();
        u.psrc = src;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_PUSH, v, req);
    endtask

    task automatic alu(alu_fn_e f, opa_e a, opb_e b, logic [15:0] v, string req);
        uinst_t u;
        u = nop();
        u.alu_fn = f;
        u.opa = a;
        u.opb = b;
        u.psrc = PSRC_ALU;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_PUSH, v, req);
    endtask

    task automatic wr_reg(int idx, bit lo, bit hi, wsrc_e s, hmode_e m,
                          logic [15:0] pop, logic [7:0] mrd);
        uinst_t u;
        u = nop();
        u.we_lo[idx] = lo;
        u.we_hi[idx] = hi;
        u.wsrc  = s;
        u.hmode = m;
        if (s == WSRC_MEM) u.mem_fn = MEM_RD_A;
        exec(u, pop, mrd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        uinst_t u;
        logic [31:0] prod;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(PSRC_A, 16'h0000, "R1 A");
        expect_sig(S_PC, 16'h0000, "R1 pc");
        peek(PSRC_B, 16'h0000, "R1 B");
        peek(PSRC_C, 16'h0000, "R1 C");

        load(REG_A, 16'h1234);
        load(REG_B, 16'h0F0F);

        // R2 arithmetic
        prod = 32'h1234 * 32'h0F0F;
        alu(ALU_PASS, OPA_REG, OPB_REG, 16'h1234, "R2 pass");
        alu(ALU_ADD,  OPA_REG, OPB_REG, 16'h2143, "R2 add");
        alu(ALU_SUB,  OPA_REG, OPB_REG, 16'h0325, "R2 sub");
        alu(ALU_MUL,  OPA_REG, OPB_REG, prod[15:0], "R2 mul");
        // R3 bitwise
        alu(ALU_EOR, OPA_REG, OPB_REG, 16'h1D3B, "R3 eor");
        alu(ALU_AND, OPA_REG, OPB_REG, 16'h0204, "R3 and");
        alu(ALU_ORA, OPA_REG, OPB_REG, 16'h1F3F, "R3 ora");
        u = nop();
        u.alu_fn = alu_fn_e'(4'd10);
        u.opb = OPB_REG;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_PUSH, 16'h0000, "R3 unused code");
        // R6 operand selects
        alu(ALU_ADD, OPA_ZERO, OPB_ONE, 16'h0001, "R6 zero+one");
        alu(ALU_ADD, OPA_REG,  OPB_ONE, 16'h1235, "R6 A+one");
        // R4 compares
        alu(ALU_EQU, OPA_REG, OPB_REG, 16'h0000, "R4 equ false");
        alu(ALU_NEQ, OPA_REG, OPB_REG, 16'h0001, "R4 neq true");
        load(REG_A, 16'h8000);
        load(REG_B, 16'h0001);
        alu(ALU_GTH, OPA_REG, OPB_REG, 16'h0001, "R4 gth unsigned");
        alu(ALU_LTH, OPA_REG, OPB_REG, 16'h0000, "R4 lth unsigned");
        load(REG_B, 16'h8000);
        alu(ALU_EQU, OPA_REG, OPB_REG, 16'h0001, "R4 equ true");
        // R5 shift
        load(REG_A, 16'h1234);
        load(REG_B, 16'h0024);
        alu(ALU_SFT, OPA_REG, OPB_REG, 16'h048C, "R5 right4 left2");
        load(REG_B, 16'h0030);
        alu(ALU_SFT, OPA_REG, OPB_REG, 16'h91A0, "R5 left3");
        load(REG_B, 16'h000F);
        alu(ALU_SFT, OPA_REG, OPB_REG, 16'h0000, "R5 right15");

        // R7 / R8 write source and high-byte modes
        wr_reg(REG_A, 1, 1, WSRC_MEM, HI_SIGN, 16'h0, 8'h9C);
        peek(PSRC_A, 16'hFF9C, "R8 sign");
        wr_reg(REG_B, 1, 1, WSRC_MEM, HI_COPY_LO, 16'h0, 8'h9C);
        peek(PSRC_B, 16'h9C9C, "R8 copy low");
        wr_reg(REG_C, 1, 1, WSRC_MEM, HI_ZERO, 16'h0, 8'h9C);
        peek(PSRC_C, 16'h009C, "R8 zero");
        u = nop();
        u.alu_fn = ALU_ADD; u.opa = OPA_ZERO; u.opb = OPB_REG;
        u.we_lo[REG_C] = 1'b1; u.we_hi[REG_C] = 1'b1;
        u.wsrc = WSRC_POP; u.hmode = HI_ALU;
        exec(u, 16'h12AB, 8'h00);
        peek(PSRC_C, 16'h9CAB, "R8 alu high");
        u = nop();
        u.alu_fn = ALU_ADD; u.opa = OPA_ZERO; u.opb = OPB_ONE;
        u.we_lo[REG_A] = 1'b1; u.we_hi[REG_A] = 1'b1;
        u.wsrc = WSRC_ALU; u.hmode = HI_SRC;
        exec(u, 16'hFFFF, 8'hFF);
        peek(PSRC_A, 16'h0001, "R7 alu source");
        wr_reg(REG_A, 1, 1, WSRC_MEM, HI_SRC, 16'hFFFF, 8'h77);
        peek(PSRC_A, 16'h0077, "R7 mem zero-extended");

        // R9 byte enables
        wr_reg(REG_C, 1, 0, WSRC_POP, HI_SRC, 16'h5566, 8'h00);
        peek(PSRC_C, 16'h9C66, "R9 low only");
        wr_reg(REG_C, 0, 1, WSRC_POP, HI_SRC, 16'h7711, 8'h00);
        peek(PSRC_C, 16'h7766, "R9 high only");
        peek(PSRC_A, 16'h0077, "R9 other register untouched");

        // R12 memory port
        load(REG_B, 16'hAB12);
        u = nop(); u.mem_fn = MEM_ST_HI; u.mem_dev = 1'b1;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_ADDR, 16'h0077, "R12 store addr");
        expect_sig(S_WDATA, 16'h00AB, "R12 store high");
        expect_sig(S_WR, 16'h1, "R12 wr strobe");
        expect_sig(S_RD, 16'h0, "R12 no rd on store");
        expect_sig(S_DEV, 16'h1, "R12 device");
        u = nop(); u.mem_fn = MEM_ST_LO;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_WDATA, 16'h0012, "R12 store low");
        expect_sig(S_DEV, 16'h0, "R12 ram");
        u = nop();
        exec(u, 16'h0, 8'h00);
        expect_sig(S_RD, 16'h0, "R12 idle rd");
        expect_sig(S_WR, 16'h0, "R12 idle wr");

        // R10 pc functions
        u = nop(); u.pc_fn = PC_STEP;
        exec(u, 16'h0, 8'h00);
        exec(u, 16'h0, 8'h00);
        expect_sig(S_PC, 16'h0001, "R10 step first");
        peek(PSRC_PC, 16'h0002, "R10 step twice");
        u = nop(); u.pc_fn = PC_HOLD;
        exec(u, 16'h0, 8'h00);
        peek(PSRC_PC, 16'h0002, "R10 hold");
        u = nop(); u.pc_fn = PC_JUMP; u.alu_fn = ALU_PASS;
        exec(u, 16'h0, 8'h00);
        peek(PSRC_PC, 16'h0077, "R10 jump alu");
        uvec = 16'h3C00;
        u = nop(); u.pc_fn = PC_VECTOR;
        exec(u, 16'h0, 8'h00);
        peek(PSRC_PC, 16'h3C00, "R10 vector");
        alu(ALU_ADD, OPA_REG, OPB_PC, 16'h3C77, "R6 A+pc");
        u = nop(); u.mem_fn = MEM_RD_PC;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_ADDR, 16'h3C00, "R12 read at pc");
        expect_sig(S_RD, 16'h1, "R12 rd strobe");

        // R11 conditional jump on BL
        load(REG_B, 16'hFF00);
        u = nop(); u.pc_fn = PC_JUMP_NZ; u.alu_fn = ALU_ADD; u.opb = OPB_PC;
        exec(u, 16'h0, 8'h00);
        peek(PSRC_PC, 16'h3C00, "R11 BL zero holds");
        load(REG_B, 16'h0001);
        u = nop(); u.pc_fn = PC_JUMP_NZ; u.alu_fn = ALU_ADD; u.opb = OPB_PC;
        exec(u, 16'h0, 8'h00);
        peek(PSRC_PC, 16'h3C77, "R11 BL nonzero jumps");

        // R13 stack port
        u = nop(); u.stk_fn = STK_PUSH; u.stk_ret = 1'b1; u.stk_size = 2'd2; u.psrc = PSRC_B;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_SPUSH, 16'h1, "R13 push");
        expect_sig(S_SPOP, 16'h0, "R13 no pop");
        expect_sig(S_SRET, 16'h1, "R13 return stack");
        expect_sig(S_SSIZE, 16'h2, "R13 size");
        expect_sig(S_PUSH, 16'h0001, "R13 push data B");
        u = nop(); u.stk_fn = STK_POP; u.stk_size = 2'd1;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_SPOP, 16'h1, "R13 pop");
        expect_sig(S_SPUSH, 16'h0, "R13 no push");
        expect_sig(S_SRET, 16'h0, "R13 working stack");

        // R14 end pulse
        u = nop(); u.last = 1'b1;
        exec(u, 16'h0, 8'h00);
        expect_sig(S_EOI, 16'h1, "R14 terminal");
        u = nop();
        exec(u, 16'h0, 8'h00);
        expect_sig(S_EOI, 16'h0, "R14 not terminal");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule